// File: doc/BRIEF.md
# PHY Discovery and Autonegotiation Sequencer

This block brings an Ethernet PHY up without software help. It sits above a management-bus master and talks to it through a narrow request port. Each request carries a PHY address, a register number, a write flag and write data. The master answers each request with a done strobe, and with read data for reads. After a start pulse the sequencer takes these steps in order:

1. It walks the PHY address space looking for a device whose identifier pair looks genuine.
2. It soft-resets the device it finds and polls until the reset bit clears.
3. It samples the vendor status register, which holds the resolved speed and duplex.
4. It turns the capability bits of the basic status register into an advertisement word and writes it.
5. It kicks off autonegotiation and polls for completion.
6. It hands speed and duplex to the MAC.

Polling is paced by a millisecond tick input, and `POLL_MS` sets the interval. A remote fault seen while polling restarts negotiation. A reset that never completes stops the sequence with a flag. A negotiation that never completes raises a flag, but speed and duplex are still applied. Only one management request is outstanding at a time, and the request fields hold steady until it is answered.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mgmt_req` and all result flags are low, and no request is issued until `start` is pulsed.
- R2: The scan visits addresses 0, 1, 2 … upward. At each address it reads register 2 and then register 3. It stops at the first address where neither word is 0x0000, 0xFFFF or 0x8000, and reports that address on `phy_addr`.
- R3: If no address qualifies, the last address (all ones) is read and then `no_phy` is set. The sequence ends with no further request.
- R4: To reset the PHY, the block writes 0x8000 to register 0 and then reads register 0. If bit 15 is clear, reset is complete. If it is set, the block waits `POLL_MS` ticks and reads again, up to `RST_POLLS` reads in all. If every read shows bit 15 set, `reset_timeout` is set and the sequence ends with no further request.
- R5: After a successful reset, register 18 is read exactly once, and register 1 is read next.
- R6: The word written to register 4 always has bit 0 set. Register 1 bits 15, 14, 13, 12 and 11 are copied to register 4 bits 9, 8, 7, 6 and 5. All other bits are zero.
- R7: After the advertisement write, 0x1200 is written to register 0 (autonegotiation enable in bit 12, restart in bit 9). Register 1 is then read at once, and again `POLL_MS` ticks after each poll. A poll with bit 5 set ends the wait.
- R8: A poll with bit 4 (remote fault) set and bit 5 clear is followed at once by another 0x1200 write to register 0, before the next wait.
- R9: After `ANEG_POLLS` polls without bit 5, `aneg_timeout` is set and the sequence finishes normally.
- R10: At the end of a sequence that reaches the negotiation stage, `mac_speed100` equals bit 7 and `mac_full_duplex` equals bit 6 of the saved register 18 value. Both are cleared when a new sequence starts.
- R11: `busy` rises the cycle after an accepted `start` and stays high until the one-cycle `done` pulse. `busy` is low in the cycle `done` is high.
- R12: `mgmt_req` is a one-cycle pulse. No new request is issued until `mgmt_done` answers the previous one, and the request fields stay unchanged meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a bring-up sequence when idle |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| mgmt_req | output | 1 | Request strobe to the management master |
| mgmt_wr | output | 1 | 1 = write, 0 = read |
| mgmt_phy | output | PHY_AW | Target PHY address |
| mgmt_reg | output | REG_AW | Target register number |
| mgmt_wdata | output | 16 | Write data |
| mgmt_done | input | 1 | Request completed strobe |
| mgmt_rdata | input | 16 | Read data, valid with `mgmt_done` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| no_phy | output | 1 | No PHY answered the scan |
| reset_timeout | output | 1 | PHY reset bit never cleared |
| aneg_timeout | output | 1 | Autonegotiation did not complete in time |
| phy_addr | output | PHY_AW | Address of the PHY that was found |
| mac_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| mac_full_duplex | output | 1 | 1 = full duplex, 0 = half |

## Verification
The bench builds the block with `POLL_MS` = 3, with the tick every 8 clocks. `RST_POLLS` (6), `ANEG_POLLS` (20) and the 5-bit address width keep their defaults. The short interval makes the full 32-address scan practical, along with both poll limits run to exhaustion and a PHY sitting at the last address. Interval spacing is measured in ticks between successive reset reads, and decoy identifier pairs exercise each rejection rule.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  localparam int unsigned MDW = 16;

  // management register numbers
  localparam logic [4:0] REG_CTRL  = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID_HI = 5'd2;
  localparam logic [4:0] REG_ID_LO = 5'd3;
  localparam logic [4:0] REG_ADV   = 5'd4;
  localparam logic [4:0] REG_VEND  = 5'd18;

  // bit positions
  localparam int unsigned CTRL_RESET   = 15;
  localparam int unsigned CTRL_AN_EN   = 12;
  localparam int unsigned CTRL_AN_RST  = 9;
  localparam int unsigned STAT_AN_DONE = 5;
  localparam int unsigned STAT_RFAULT  = 4;
  localparam int unsigned VEND_SPD     = 7;
  localparam int unsigned VEND_DPX     = 6;

  typedef enum logic [3:0] {
    OP_ID_HI, OP_ID_LO, OP_RST_WR, OP_RST_RD, OP_VEND_RD,
    OP_CAP_RD, OP_ADV_WR, OP_AN_WR, OP_AN_POLL
  } mgmt_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_DELAY, ST_END
  } seq_state_e;

  typedef struct packed {
    logic           wr;
    logic [4:0]     regno;
    logic [MDW-1:0] wdata;
  } mgmt_cmd_t;

endpackage

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
  parameter int unsigned INTERVAL = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      expire   <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (arm) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q && tick) begin
        if (cnt_q == CW'(INTERVAL - 1)) begin
          active_q <= 1'b0;
          expire   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/phy_id_check.sv
module phy_id_check #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] id_hi,
  input  logic [DW-1:0] id_lo,
  output logic          valid
);
  logic [1:0] word_ok;

  for (genvar i = 0; i < 2; i++) begin : g_word
    logic [DW-1:0] w;
    assign w = (i == 0) ? id_hi : id_lo;
    assign word_ok[i] = (w != '0) && (w != '1) &&
                        (w != (DW'(1) << (DW - 1)));
  end

  assign valid = &word_ok;
endmodule

// File: rtl/phy_adv_map.sv
module phy_adv_map #(
  parameter int unsigned NCAP = 5
) (
  input  logic [NCAP-1:0] caps_hi,
  output logic [15:0]     adv
);
  localparam int unsigned TOP = 4 + NCAP;

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    assign adv[TOP - i] = caps_hi[NCAP - 1 - i];
  end

  assign adv[15:TOP+1] = '0;
  assign adv[4:1]      = '0;
  assign adv[0]        = 1'b1;
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int unsigned PHY_AW     = 5,
  parameter int unsigned REG_AW     = 5,
  parameter int unsigned POLL_MS    = 500,
  parameter int unsigned RST_POLLS  = 6,
  parameter int unsigned ANEG_POLLS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ms_tick,
  output logic              mgmt_req,
  output logic              mgmt_wr,
  output logic [PHY_AW-1:0] mgmt_phy,
  output logic [REG_AW-1:0] mgmt_reg,
  output logic [15:0]       mgmt_wdata,
  input  logic              mgmt_done,
  input  logic [15:0]       mgmt_rdata,
  output logic              busy,
  output logic              done,
  output logic              no_phy,
  output logic              reset_timeout,
  output logic              aneg_timeout,
  output logic [PHY_AW-1:0] phy_addr,
  output logic              mac_speed100,
  output logic              mac_full_duplex
);
  localparam int unsigned POLL_MAX = (RST_POLLS > ANEG_POLLS) ? RST_POLLS : ANEG_POLLS;
  localparam int unsigned PCW      = $clog2(POLL_MAX + 1);

  seq_state_e        state_q;
  mgmt_op_e          op_q;
  logic [PHY_AW-1:0] scan_q;
  logic [15:0]       id_hi_q;
  logic [1:0]        vend_q;
  logic [15:0]       adv_q;
  logic [PCW-1:0]    pcnt_q;
  logic              refault_q;
  logic              arm_q;
  logic              tmr_exp;
  logic              id_ok;
  logic [15:0]       adv_word;
  mgmt_cmd_t         cmd;

  phy_poll_timer #(.INTERVAL(POLL_MS)) u_timer (
    .clk(clk), .rst(rst), .arm(arm_q), .tick(ms_tick), .expire(tmr_exp)
  );

  phy_id_check #(.DW(16)) u_idchk (
    .id_hi(id_hi_q), .id_lo(mgmt_rdata), .valid(id_ok)
  );

  phy_adv_map #(.NCAP(5)) u_adv (
    .caps_hi(mgmt_rdata[15:11]), .adv(adv_word)
  );

  // request encoding for the pending operation
  always_comb begin
    cmd = '{wr: 1'b0, regno: REG_CTRL, wdata: 16'h0000};
    case (op_q)
      OP_ID_HI:   cmd.regno = REG_ID_HI;
      OP_ID_LO:   cmd.regno = REG_ID_LO;
      OP_RST_WR:  begin cmd.wr = 1'b1; cmd.wdata[CTRL_RESET] = 1'b1; end
      OP_RST_RD:  cmd.regno = REG_CTRL;
      OP_VEND_RD: cmd.regno = REG_VEND;
      OP_CAP_RD:  cmd.regno = REG_STAT;
      OP_ADV_WR:  begin cmd.wr = 1'b1; cmd.regno = REG_ADV; cmd.wdata = adv_q; end
      OP_AN_WR:   begin
                    cmd.wr = 1'b1;
                    cmd.wdata[CTRL_AN_EN]  = 1'b1;
                    cmd.wdata[CTRL_AN_RST] = 1'b1;
                  end
      OP_AN_POLL: cmd.regno = REG_STAT;
      default:    cmd.regno = REG_CTRL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      op_q            <= OP_ID_HI;
      scan_q          <= '0;
      id_hi_q         <= '0;
      vend_q          <= '0;
      adv_q           <= '0;
      pcnt_q          <= '0;
      refault_q       <= 1'b0;
      arm_q           <= 1'b0;
      mgmt_req        <= 1'b0;
      mgmt_wr         <= 1'b0;
      mgmt_phy        <= '0;
      mgmt_reg        <= '0;
      mgmt_wdata      <= '0;
      busy            <= 1'b0;
      done            <= 1'b0;
      no_phy          <= 1'b0;
      reset_timeout   <= 1'b0;
      aneg_timeout    <= 1'b0;
      phy_addr        <= '0;
      mac_speed100    <= 1'b0;
      mac_full_duplex <= 1'b0;
    end else begin
      mgmt_req <= 1'b0;
      done     <= 1'b0;
      arm_q    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            busy            <= 1'b1;
            no_phy          <= 1'b0;
            reset_timeout   <= 1'b0;
            aneg_timeout    <= 1'b0;
            mac_speed100    <= 1'b0;
            mac_full_duplex <= 1'b0;
            phy_addr        <= '0;
            scan_q          <= '0;
            op_q            <= OP_ID_HI;
            state_q         <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          mgmt_req   <= 1'b1;
          mgmt_wr    <= cmd.wr;
          mgmt_phy   <= scan_q;
          mgmt_reg   <= REG_AW'(cmd.regno);
          mgmt_wdata <= cmd.wdata;
          state_q    <= ST_WAIT;
        end
        ST_DELAY: begin
          if (tmr_exp) state_q <= ST_ISSUE;
        end
        ST_WAIT: begin
          if (mgmt_done) begin
            case (op_q)
              OP_ID_HI: begin
                id_hi_q <= mgmt_rdata;
                op_q    <= OP_ID_LO;
                state_q <= ST_ISSUE;
              end
              OP_ID_LO: begin
                if (id_ok) begin
                  phy_addr <= scan_q;
                  op_q     <= OP_RST_WR;
                  state_q  <= ST_ISSUE;
                end else if (&scan_q) begin
                  no_phy  <= 1'b1;
                  state_q <= ST_END;
                end else begin
                  scan_q  <= scan_q + PHY_AW'(1);
                  op_q    <= OP_ID_HI;
                  state_q <= ST_ISSUE;
                end
              end
              OP_RST_WR: begin
                pcnt_q  <= '0;
                op_q    <= OP_RST_RD;
                state_q <= ST_ISSUE;
              end
              OP_RST_RD: begin
                if (!mgmt_rdata[CTRL_RESET]) begin
                  op_q    <= OP_VEND_RD;
                  state_q <= ST_ISSUE;
                end else if (pcnt_q == PCW'(RST_POLLS - 1)) begin
                  reset_timeout <= 1'b1;
                  state_q       <= ST_END;
                end else begin
                  pcnt_q  <= pcnt_q + PCW'(1);
                  arm_q   <= 1'b1;
                  state_q <= ST_DELAY;
                end
              end
              OP_VEND_RD: begin
                vend_q  <= {mgmt_rdata[VEND_SPD], mgmt_rdata[VEND_DPX]};
                op_q    <= OP_CAP_RD;
                state_q <= ST_ISSUE;
              end
              OP_CAP_RD: begin
                adv_q   <= adv_word;
                op_q    <= OP_ADV_WR;
                state_q <= ST_ISSUE;
              end
              OP_ADV_WR: begin
                pcnt_q    <= '0;
                refault_q <= 1'b0;
                op_q      <= OP_AN_WR;
                state_q   <= ST_ISSUE;
              end
              OP_AN_WR: begin
                op_q <= OP_AN_POLL;
                if (refault_q) begin
                  refault_q <= 1'b0;
                  arm_q     <= 1'b1;
                  state_q   <= ST_DELAY;
                end else begin
                  state_q <= ST_ISSUE;
                end
              end
              OP_AN_POLL: begin
                if (mgmt_rdata[STAT_AN_DONE] || pcnt_q == PCW'(ANEG_POLLS - 1)) begin
                  aneg_timeout    <= !mgmt_rdata[STAT_AN_DONE];
                  mac_speed100    <= vend_q[1];
                  mac_full_duplex <= vend_q[0];
                  state_q         <= ST_END;
                end else begin
                  pcnt_q <= pcnt_q + PCW'(1);
                  if (mgmt_rdata[STAT_RFAULT]) begin
                    refault_q <= 1'b1;
                    op_q      <= OP_AN_WR;
                    state_q   <= ST_ISSUE;
                  end else begin
                    arm_q   <= 1'b1;
                    state_q <= ST_DELAY;
                  end
                end
              end
              default: state_q <= ST_END;
            endcase
          end
        end
        ST_END: begin
          busy    <= 1'b0;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk #(
  parameter int unsigned PHY_AW = 5,
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mgmt_req,
  input logic              mgmt_wr,
  input logic [PHY_AW-1:0] mgmt_phy,
  input logic [REG_AW-1:0] mgmt_reg,
  input logic [15:0]       mgmt_wdata,
  input logic              mgmt_done,
  input logic              no_phy,
  input logic              reset_timeout
);
  logic pending_q;

  always_ff @(posedge clk) begin
    if (rst)            pending_q <= 1'b0;
    else if (mgmt_req)  pending_q <= 1'b1;
    else if (mgmt_done) pending_q <= 1'b0;
  end

  assert_req_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    mgmt_req |=> !mgmt_req);

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (rst)
    mgmt_req |-> !pending_q);

  assert_fields_hold_R12: assert property (@(posedge clk) disable iff (rst)
    pending_q |-> $stable({mgmt_wr, mgmt_phy, mgmt_reg, mgmt_wdata}));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mgmt_req);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_ends_with_done_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_no_phy_silent_R3: assert property (@(posedge clk) disable iff (rst)
    no_phy |-> !mgmt_req);

  assert_rst_timeout_silent_R4: assert property (@(posedge clk) disable iff (rst)
    reset_timeout |-> !mgmt_req);

  assert_adv_selector_R6: assert property (@(posedge clk) disable iff (rst)
    (mgmt_req && mgmt_wr && mgmt_reg == REG_AW'(4)) |-> mgmt_wdata[0]);
endmodule

bind phy_bringup_seq phy_bringup_chk #(.PHY_AW(PHY_AW), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mgmt_req(mgmt_req), .mgmt_wr(mgmt_wr), .mgmt_phy(mgmt_phy),
  .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata), .mgmt_done(mgmt_done),
  .no_phy(no_phy), .reset_timeout(reset_timeout)
);

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int POLL       = 3;
  localparam int TICK_DIV   = 8;
  localparam int RSTP       = 6;
  localparam int ANP        = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        start = 1'b0;
  logic        ms_tick = 1'b0;
  logic        mgmt_req, mgmt_wr;
  logic [4:0]  mgmt_phy, mgmt_reg;
  logic [15:0] mgmt_wdata;
  logic        mgmt_done = 1'b0;
  logic [15:0] mgmt_rdata = 16'h0;
  logic        busy, done, no_phy, reset_timeout, aneg_timeout;
  logic [4:0]  phy_addr;
  logic        mac_speed100, mac_full_duplex;

  phy_bringup_seq #(
    .PHY_AW(5), .REG_AW(5), .POLL_MS(POLL), .RST_POLLS(RSTP), .ANEG_POLLS(ANP)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
    .mgmt_req(mgmt_req), .mgmt_wr(mgmt_wr), .mgmt_phy(mgmt_phy),
    .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata), .mgmt_done(mgmt_done),
    .mgmt_rdata(mgmt_rdata), .busy(busy), .done(done), .no_phy(no_phy),
    .reset_timeout(reset_timeout), .aneg_timeout(aneg_timeout),
    .phy_addr(phy_addr), .mac_speed100(mac_speed100),
    .mac_full_duplex(mac_full_duplex)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int tick_count = 0;

  typedef struct {
    bit    wr;
    int    phy;
    int    regno;
    int    wd;
    string tag;
  } item_t;
  item_t exq[$];
  int    rst_stamps[$];

  // PHY model configuration
  int          phy_at;
  bit          use_decoys;
  int          rst_clear_at;
  int          an_done_at;
  int          fault_at;
  logic [15:0] caps;
  logic [15:0] r18;
  int          rst_reads;
  int          stat_reads;

  task automatic check_eq(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit wr, input int phy, input int regno, input int wd, input string tag);
    item_t it;
    it.wr = wr; it.phy = phy; it.regno = regno; it.wd = wd; it.tag = tag;
    exq.push_back(it);
  endtask

  function automatic logic [15:0] decoy(input int a, input int r);
    if (!use_decoys) return 16'hFFFF;
    case (a)
      0: return (r == 2) ? 16'hFFFF : 16'h1234;
      1: return (r == 2) ? 16'h0000 : 16'h1234;
      2: return (r == 2) ? 16'h1234 : 16'h8000;
      3: return (r == 2) ? 16'h8000 : 16'h1234;
      4: return (r == 2) ? 16'h1234 : 16'hFFFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  // ms tick source
  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      ms_tick = 1'b1;
      tick_count++;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  // monitor + management model: pops expected requests and answers them
  task automatic serve();
    item_t       e;
    logic [15:0] rd;
    int          idx;
    if (exq.size() == 0) begin
      tests++; fails++;
      $display("FAIL R12 unexpected request: actual reg %0d phy %0d expected none", mgmt_reg, mgmt_phy);
    end else begin
      e = exq.pop_front();
      check_eq(e.tag, "write flag", mgmt_wr, e.wr);
      check_eq(e.tag, "phy address", mgmt_phy, e.phy);
      check_eq(e.tag, "register", mgmt_reg, e.regno);
      if (e.wr) check_eq(e.tag, "write data", mgmt_wdata, e.wd);
    end
    rd = 16'h0;
    if (!mgmt_wr) begin
      if (int'(mgmt_phy) != phy_at) rd = decoy(int'(mgmt_phy), int'(mgmt_reg));
      else begin
        case (int'(mgmt_reg))
          2: rd = 16'h0016;
          3: rd = 16'hF841;
          0: begin
            rst_stamps.push_back(tick_count);
            rd = (rst_clear_at < 0 || rst_reads < rst_clear_at) ? 16'h8000 : 16'h0000;
            rst_reads++;
          end
          18: rd = r18;
          1: begin
            idx = stat_reads - 1;
            rd  = caps;
            if (idx >= 0 && an_done_at >= 0 && idx >= an_done_at) rd = rd | 16'h0020;
            if (idx >= 0 && idx == fault_at) rd = rd | 16'h0010;
            stat_reads++;
          end
          default: rd = 16'h0;
        endcase
      end
    end
    repeat (2) @(negedge clk);
    mgmt_rdata = rd;
    mgmt_done  = 1'b1;
    @(negedge clk);
    mgmt_done  = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mgmt_req) serve();
    end
  end

  // expected-traffic builders
  task automatic exp_scan(input int last, input string tag);
    for (int a = 0; a <= last; a++) begin
      push(1'b0, a, 2, 0, tag);
      push(1'b0, a, 3, 0, tag);
    end
  endtask

  task automatic exp_reset(input int phy, input int reads);
    push(1'b1, phy, 0, 'h8000, "R4");
    for (int k = 0; k < reads; k++) push(1'b0, phy, 0, 0, "R4");
  endtask

  task automatic exp_cfg(input int phy, input int adv);
    push(1'b0, phy, 18, 0, "R5");
    push(1'b0, phy, 1, 0, "R5");
    push(1'b1, phy, 4, adv, "R6");
  endtask

  task automatic exp_an(input int phy, input int polls, input int fault);
    push(1'b1, phy, 0, 'h1200, "R7");
    for (int k = 0; k < polls; k++) begin
      push(1'b0, phy, 1, 0, (polls == ANP && k == polls - 1) ? "R9" : "R7");
      if (k == fault && k < polls - 1) push(1'b1, phy, 0, 'h1200, "R8");
    end
  endtask

  task automatic check_gaps();
    for (int i = 1; i < rst_stamps.size(); i++) begin
      int gap;
      gap = rst_stamps[i] - rst_stamps[i-1];
      check_eq("R4", "reset poll spacing in range", (gap >= POLL && gap <= POLL + 1), 1);
    end
  endtask

  task automatic run_case(input string tag, input bit e_no, input bit e_rto, input bit e_ato,
                          input bit e_spd, input bit e_dpx, input int e_addr);
    rst_reads = 0; stat_reads = 0; rst_stamps.delete();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check_eq("R11", "busy after start", busy, 1);
    check_eq("R10", "speed cleared on start", mac_speed100, 0);
    check_eq("R10", "duplex cleared on start", mac_full_duplex, 0);
    while (done !== 1'b1) @(negedge clk);
    check_eq("R11", "busy during done", busy, 0);
    check_eq("R3", "no_phy flag", no_phy, e_no);
    check_eq("R4", "reset_timeout flag", reset_timeout, e_rto);
    check_eq("R9", "aneg_timeout flag", aneg_timeout, e_ato);
    check_eq("R10", "speed result", mac_speed100, e_spd);
    check_eq("R10", "duplex result", mac_full_duplex, e_dpx);
    if (!e_no) check_eq("R2", "found address", phy_addr, e_addr);
    @(negedge clk);
    check_eq("R11", "done is one cycle", done, 0);
    repeat (40) @(negedge clk);
    check_eq(tag, "expected requests left over", exq.size(), 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "done after reset", done, 0);
    check_eq("R1", "req after reset", mgmt_req, 0);
    check_eq("R1", "flags after reset", {no_phy, reset_timeout, aneg_timeout}, 0);
    repeat (20) @(negedge clk);
    check_eq("R1", "no request without start", mgmt_req, 0);

    // case 1: PHY at 0, all capabilities, immediate reset and negotiation
    phy_at = 0; use_decoys = 0; rst_clear_at = 0; an_done_at = 0; fault_at = -1;
    caps = 16'hF800; r18 = 16'h00C0;
    exp_scan(0, "R2"); exp_reset(0, 1); exp_cfg(0, 'h03E1); exp_an(0, 1, -1);
    run_case("R7", 0, 0, 0, 1, 1, 0);

    // case 2: decoys before address 5, slow reset, remote fault then success
    phy_at = 5; use_decoys = 1; rst_clear_at = 2; an_done_at = 3; fault_at = 1;
    caps = 16'h2800; r18 = 16'h0080;
    exp_scan(5, "R2"); exp_reset(5, 3); exp_cfg(5, 'h00A1); exp_an(5, 4, 1);
    run_case("R8", 0, 0, 0, 1, 0, 5);
    check_gaps();

    // case 3: nothing answers
    phy_at = 99; use_decoys = 0;
    exp_scan(31, "R3");
    run_case("R3", 1, 0, 0, 0, 0, 0);

    // case 4: PHY at last address, reset never clears
    phy_at = 31; use_decoys = 0; rst_clear_at = -1;
    exp_scan(31, "R2"); exp_reset(31, RSTP);
    run_case("R4", 0, 1, 0, 0, 0, 31);
    check_eq("R4", "reset read count", rst_stamps.size(), RSTP);
    check_gaps();

    // case 5: negotiation never completes
    phy_at = 2; use_decoys = 0; rst_clear_at = 0; an_done_at = -1; fault_at = -1;
    caps = 16'h9000; r18 = 16'h0040;
    exp_scan(2, "R2"); exp_reset(2, 1); exp_cfg(2, 'h0241); exp_an(2, ANP, -1);
    run_case("R9", 0, 0, 1, 0, 1, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule